// File: doc/BRIEF.md
# Prescaled Timer with Alarm and Latched Interrupt Controller

This block keeps a free-running tick counter for a control processor. A prescaler divides the core clock by a fixed ratio, and the counter advances once for each prescaler wrap. Software can load the counter at any time, and each load restarts the prescaler. A programmable alarm value is compared against the counter. When the counter reaches the alarm value, the alarm source in a sticky interrupt status register is set.

The status register also collects a vector of synchronous interrupt request lines and two asynchronous push-button inputs. Each button is synchronised and edge-detected, so one press latches one event into a fixed bit. Software clears a status bit by writing a one to it. A separate enable register chooses which latched bits drive the single interrupt line. The block does not encode priority and does not produce vectors.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: With no register write, the tick counter (register 0) increases by exactly one every 128 clock cycles, wrapping at its full width.
- R2: A write to register 0 loads the written value at that clock edge and restarts the prescaler. The next increment happens on the 128th edge after the write.
- R3: When the counter becomes equal to the alarm value (register 1), status bit 0 is set on the following clock edge. This happens once for each onset of equality. The alarm value resets to all ones.
- R4: Writing register 2 clears each status bit whose written bit is 1. Bits written as 0 keep their value.
- R5: If irq_req[i] is high at a clock edge, status bit i is set at that edge. The bit then stays set until software clears it.
- R6: A rising edge on btn_power sets status bit 11, and a rising edge on btn_reset sets status bit 17. Each input passes through two synchroniser flops, so the bit is set on the third clock edge after the input rises. A held press sets its bit only once.
- R7: If a bit's set event and its write-one-to-clear arrive at the same edge, the set wins and the bit stays 1.
- R8: Register 3 holds the enable mask. irq_out is high exactly when some status bit and the same enable bit are both 1.
- R9: Register reads are combinational on bus_addr: 0 is the counter, 1 is the alarm, 2 is the status and 3 is the enable. After reset these read 0, all ones, 0 and 0, and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select (0 counter, 1 alarm, 2 status, 3 enable) |
| bus_wr_en | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_req | input | 32 | Synchronous interrupt requests, one per status bit |
| btn_reset | input | 1 | Asynchronous reset-button level |
| btn_power | input | 1 | Asynchronous power-button level |
| irq_out | output | 1 | Enabled-and-latched interrupt summary |

## Verification
The bench reads the counter on every cycle across two prescaler wraps after a load. A prescaler that is not restarted by the load, or that divides by 127 or 129, moves the increment by at least one cycle. The alarm bit is watched cycle by cycle across the onset of equality. A design that compares one tick late, or that fires on every cycle of equality, shows up as a late bit or as a bit that comes back after it is cleared.

Every status bit is set, masked and cleared in turn. This catches a swapped enable polarity, a clear that ignores the written zeros, and a set that loses to a clear arriving at the same edge. The buttons are held down across a clear. A missing edge detector sets the bit again, and a missing synchroniser stage changes the latency.

// File: rtl/tmr_irq_pkg.sv
// Shared register selector for the timer/interrupt block.
package tmr_irq_pkg;
    typedef enum logic [1:0] {
        SEL_TICKS  = 2'd0,
        SEL_ALARM  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_tick_counter.sv
// Prescaled tick counter with alarm comparator.
// Assumes PRESCALE >= 2. The alarm event is a one-cycle pulse at the onset
// of counter == alarm.
module tmr_tick_counter #(
    parameter int TMR_W    = 32,
    parameter int PRESCALE = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [TMR_W-1:0] load_val,
    input  logic             alarm_wr,
    input  logic [TMR_W-1:0] alarm_val,
    output logic [TMR_W-1:0] ticks_q,
    output logic [TMR_W-1:0] alarm_q,
    output logic             alarm_evt
);
    localparam int PS_W = $clog2(PRESCALE);
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0] ps_q;
    logic            hit;
    logic            hit_d;

    // Prescaler and counter: a load restarts the division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= '0;
            ticks_q <= '0;
        end else if (load_en) begin
            ps_q    <= '0;
            ticks_q <= load_val;
        end else if (ps_q == PS_LAST) begin
            ps_q    <= '0;
            ticks_q <= ticks_q + TMR_W'(1);
        end else begin
            ps_q    <= ps_q + PS_W'(1);
        end
    end

    // Alarm register, reset far away from the counter's reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '1;
        else if (alarm_wr) alarm_q <= alarm_val;
    end

    // Registered equality, so the event fires only at the onset.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_d <= 1'b0;
        else        hit_d <= hit;
    end

    assign hit       = (ticks_q == alarm_q);
    assign alarm_evt = hit & ~hit_d;

    a_r1_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && ps_q != PS_LAST) |=> $stable(ticks_q));
    a_r1_step_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && ps_q == PS_LAST) |=> (ticks_q == $past(ticks_q) + TMR_W'(1)));
    a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ticks_q == $past(load_val) && ps_q == '0));
    a_r3_single_alarm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt);
endmodule

// File: rtl/tmr_edge_sync.sv
// Two-flop synchroniser followed by a rising-edge detector.
// Assumes async_in is a slow level, such as a button.
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [1:0] sync_q;
    logic       prev_q;

    // Synchronise the level and keep its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], async_in};
            prev_q <= sync_q[1];
        end
    end

    assign rise_pulse = sync_q[1] & ~prev_q;

    a_r6_one_pulse_per_press: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/tmr_irq_status.sv
// Sticky interrupt status with write-one-to-clear and an enable mask.
// A set event beats a clear of the same bit at the same edge.
module tmr_irq_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         en_wr,
    input  logic [N-1:0] en_val,
    output logic [N-1:0] status_q,
    output logic [N-1:0] enable_q,
    output logic         irq_out
);
    // Latch events and clear acknowledged bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= '0;
        else if (en_wr) enable_q <= en_val;
    end

    assign irq_out = |(status_q & enable_q);

    a_r4_cleared_bits_drop: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));
    a_r5_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq_out);
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Top: register decode around the tick counter, button edge detectors and
// interrupt status. Assumes the status bit positions are distinct and < DATA_W.
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PRESCALE  = 128,
    parameter int ALARM_BIT = 0,
    parameter int PWR_BIT   = 11,
    parameter int RST_BIT   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] irq_req,
    input  logic              btn_reset,
    input  logic              btn_power,
    output logic              irq_out
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] ticks, alarm, status, enable;
    logic [DATA_W-1:0] set_vec, clr_vec;
    logic              alarm_evt, pwr_rise, rst_rise;

    assign sel = reg_sel_e'(bus_addr);

    tmr_tick_counter #(.TMR_W(DATA_W), .PRESCALE(PRESCALE)) u_ticks (
        .clk(clk), .rst_n(rst_n),
        .load_en(bus_wr_en && sel == SEL_TICKS), .load_val(bus_wdata),
        .alarm_wr(bus_wr_en && sel == SEL_ALARM), .alarm_val(bus_wdata),
        .ticks_q(ticks), .alarm_q(alarm), .alarm_evt(alarm_evt)
    );

    tmr_edge_sync u_pwr (.clk(clk), .rst_n(rst_n), .async_in(btn_power), .rise_pulse(pwr_rise));
    tmr_edge_sync u_rst (.clk(clk), .rst_n(rst_n), .async_in(btn_reset), .rise_pulse(rst_rise));

    // Merge the external requests with the internal event sources.
    always_comb begin
        set_vec            = irq_req;
        set_vec[ALARM_BIT] = irq_req[ALARM_BIT] | alarm_evt;
        set_vec[PWR_BIT]   = irq_req[PWR_BIT]   | pwr_rise;
        set_vec[RST_BIT]   = irq_req[RST_BIT]   | rst_rise;
    end

    // Clear mask is the write data of a status write.
    assign clr_vec = (bus_wr_en && sel == SEL_STATUS) ? bus_wdata : '0;

    tmr_irq_status #(.N(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .en_wr(bus_wr_en && sel == SEL_ENABLE), .en_val(bus_wdata),
        .status_q(status), .enable_q(enable), .irq_out(irq_out)
    );

    // Read multiplexer.
    always_comb begin
        case (sel)
            SEL_TICKS:  bus_rdata = ticks;
            SEL_ALARM:  bus_rdata = alarm;
            SEL_STATUS: bus_rdata = status;
            default:    bus_rdata = enable;
        endcase
    end

    a_r3_alarm_latches: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> status[ALARM_BIT]);
endmodule

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_req = '0;
    logic        btn_reset = 1'b0;
    logic        btn_power = 1'b0;
    logic        irq_out;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    tmr_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .btn_reset(btn_reset), .btn_power(btn_power), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write during one clock; returns at the negedge just after the write edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R9 reset values
        rdreg(2'd0, rd); chk("R9 counter reset", rd, 32'h0);
        rdreg(2'd1, rd); chk("R9 alarm reset", rd, 32'hFFFF_FFFF);
        rdreg(2'd2, rd); chk("R9 status reset", rd, 32'h0);
        rdreg(2'd3, rd); chk("R9 enable reset", rd, 32'h0);
        chk("R9 irq reset", {31'b0, irq_out}, 32'h0);

        // R1/R2: load near the wrap and follow the counter for every cycle
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFE);
        for (int k = 0; k < 300; k++) begin
            rdreg(2'd0, rd);
            chk("R1 R2 counter step", rd, 32'hFFFF_FFFE + 32'(k / 128));
            @(negedge clk);
        end
        // R3: the alarm at 0xFFFFFFFF was reached at k=128, so the bit is latched
        rdreg(2'd2, rd); chk("R3 alarm latched", rd, 32'h1);
        wr(2'd2, 32'h1);
        rdreg(2'd2, rd); chk("R4 alarm cleared", rd, 32'h0);

        // R3: alarm = W+2, watch status bit 0 each cycle
        wr(2'd1, 32'd1002);
        wr(2'd0, 32'd1000);
        for (int k = 0; k < 300; k++) begin
            rdreg(2'd2, rd);
            chk("R3 alarm onset", rd, (k >= 257) ? 32'h1 : 32'h0);
            @(negedge clk);
        end
        wr(2'd2, 32'h1);
        idle(20);
        rdreg(2'd2, rd); chk("R3 no refire while equal", rd, 32'h0);
        rdreg(2'd0, rd); chk("R3 counter still equal", rd, 32'd1002);

        // R5/R8/R4: every bit set, masked, held by a zero write, cleared
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); irq_req = 32'h1 << i;
            @(negedge clk); irq_req = '0;
            idle(2);
            rdreg(2'd2, rd); chk("R5 request latched", rd, 32'h1 << i);
            chk("R8 irq masked off", {31'b0, irq_out}, 32'h0);
            wr(2'd3, ~(32'h1 << i));
            chk("R8 other enables", {31'b0, irq_out}, 32'h0);
            wr(2'd3, 32'h1 << i);
            chk("R8 enabled bit", {31'b0, irq_out}, 32'h1);
            wr(2'd2, ~(32'h1 << i));
            rdreg(2'd2, rd); chk("R4 zero bit kept", rd, 32'h1 << i);
            wr(2'd2, 32'h1 << i);
            rdreg(2'd2, rd); chk("R4 one bit cleared", rd, 32'h0);
            chk("R8 irq drops", {31'b0, irq_out}, 32'h0);
        end
        wr(2'd3, 32'h0);

        // R7: set and clear at the same edge
        @(negedge clk);
        irq_req = 32'h20; bus_addr = 2'd2; bus_wdata = 32'h20; bus_wr_en = 1'b1;
        @(negedge clk);
        irq_req = '0; bus_wr_en = 1'b0;
        rdreg(2'd2, rd); chk("R7 set wins", rd, 32'h20);
        wr(2'd2, 32'h20);

        // R6: power button latency, single event while held, and a re-press
        @(negedge clk); btn_power = 1'b1;
        @(negedge clk); rdreg(2'd2, rd); chk("R6 pwr edge1", rd, 32'h0);
        @(negedge clk); rdreg(2'd2, rd); chk("R6 pwr edge2", rd, 32'h0);
        @(negedge clk); rdreg(2'd2, rd); chk("R6 pwr edge3", rd, 32'h800);
        idle(5);
        wr(2'd2, 32'h800);
        idle(10);
        rdreg(2'd2, rd); chk("R6 pwr held once", rd, 32'h0);
        btn_power = 1'b0;
        idle(5);
        btn_power = 1'b1;
        idle(4);
        rdreg(2'd2, rd); chk("R6 pwr repress", rd, 32'h800);
        btn_power = 1'b0;
        wr(2'd2, 32'h800);

        // R6: reset button
        @(negedge clk); btn_reset = 1'b1;
        @(negedge clk); @(negedge clk); rdreg(2'd2, rd); chk("R6 rst edge2", rd, 32'h0);
        @(negedge clk); rdreg(2'd2, rd); chk("R6 rst edge3", rd, 32'h20000);
        wr(2'd2, 32'h20000);
        idle(8);
        rdreg(2'd2, rd); chk("R6 rst held once", rd, 32'h0);
        btn_reset = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule